// File: doc/BRIEF.md
# Packed 64-bit SIMD Integer ALU

This block is a packed-integer execution unit. Each operation supplies a destination operand, a source operand and an 8-bit operation code. The 64-bit operands are read as eight byte lanes, four word lanes, two dword lanes or one qword, depending on the operation. The unit returns a 64-bit result. It supports:

- unsigned saturating and wrap-around word addition;
- bitwise AND and AND-NOT;
- rounded averaging of bytes and of words;
- lane equality masks on bytes, words and dwords;
- a signed byte greater-than mask.

Operations enter through a valid/ready port at up to one per cycle. They leave in order on a valid/ready result port, exactly two cycles later when the consumer is ready. A result from an unsupported code is all zeros and carries an illegal-operation flag in the same result slot. The source operand may come from a register or from memory. Either way it arrives on the same input, so the unit treats both forms alike.

Top module: `simd_alu_top`

## Requirements
- R1: After a synchronous active-low reset, `res_valid` is low and `op_ready` is high.
- R2: Code DDh adds each 16-bit lane as unsigned; a lane whose sum exceeds FFFFh yields FFFFh.
- R3: Code FDh adds each 16-bit lane and keeps the low 16 bits of the sum.
- R4: Code DBh yields `dst & src`; code DFh yields `~dst & src` over all 64 bits.
- R5: Code E0h (byte lanes) and E3h (word lanes) yield (a + b + 1) >> 1 per lane, with the carry kept, so FFh and FFh average to FFh.
- R6: Codes 74h, 75h and 76h compare byte, word and dword lanes for equality, writing all ones on a match and all zeros otherwise.
- R7: Code 64h writes FFh to each byte lane where the destination byte, read as signed two's complement, is greater than the source byte, and 00h otherwise.
- R8: Any other code gives a zero result with `res_illegal` high; supported codes give `res_illegal` low.
- R9: An operation accepted at the end of cycle c is presented on the result port in cycle c+2 when `res_ready` is high in cycle c+1.
- R10: While `res_valid` is high and `res_ready` is low, the result and flag hold steady. Results leave in acceptance order with none lost. `op_ready` is low only when both pipeline stages hold work and `res_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The unit accepts the offered operation this cycle |
| op_code | input | 8 | Operation code (second byte after the 0Fh escape) |
| op_dst | input | 64 | Destination operand |
| op_src | input | 64 | Source operand, register or memory |
| res_valid | output | 1 | A result is presented |
| res_ready | input | 1 | The consumer takes the result this cycle |
| res_data | output | 64 | Result |
| res_illegal | output | 1 | The result belongs to an unsupported code |

## Verification
Directed operands put lanes at the arithmetic edges: sums that overflow by exactly one, sums that just fit, averages of FFh with FFh, and signed bytes at 80h and 7Fh. These separate saturation from wrapping, a rounding that keeps the carry from one that drops it, and signed from unsigned comparison. Equality vectors mix matching and non-matching lanes within one qword, so a wrong lane width or lane order shows up. A stalled phase fills both stages and holds them. Random operations with a random consumer stall then check ordering and the zeroing of unsupported codes against a behavioural model.

// File: rtl/simd_alu_pkg.sv
// Package: operation kinds and fixed code values shared by the ALU blocks.
// Assumes the opcode byte is the one that follows the 0Fh escape.
package simd_alu_pkg;

    typedef enum logic [3:0] {
        K_ADD_SAT_W,
        K_ADD_WRAP_W,
        K_AND,
        K_AND_NOT,
        K_AVG_B,
        K_AVG_W,
        K_EQ_B,
        K_EQ_W,
        K_EQ_D,
        K_GT_B,
        K_NONE
    } op_kind_e;

    localparam logic [7:0] CODE_ADD_SAT_W  = 8'hDD;
    localparam logic [7:0] CODE_ADD_WRAP_W = 8'hFD;
    localparam logic [7:0] CODE_AND        = 8'hDB;
    localparam logic [7:0] CODE_AND_NOT    = 8'hDF;
    localparam logic [7:0] CODE_AVG_B      = 8'hE0;
    localparam logic [7:0] CODE_AVG_W      = 8'hE3;
    localparam logic [7:0] CODE_EQ_B       = 8'h74;
    localparam logic [7:0] CODE_EQ_W       = 8'h75;
    localparam logic [7:0] CODE_EQ_D       = 8'h76;
    localparam logic [7:0] CODE_GT_B       = 8'h64;

    localparam int KIND_W = $bits(op_kind_e);

endpackage

// File: rtl/simd_alu_decode.sv
// Decoder: maps the opcode byte onto an operation kind.
// Assumes: purely combinational; an unknown code maps to K_NONE and raises illegal.
module simd_alu_decode
    import simd_alu_pkg::*;
(
    input  logic [7:0] code,
    output op_kind_e   kind,
    output logic       illegal
);

    // Translate the fixed code map into an internal kind.
    always_comb begin
        illegal = 1'b0;
        unique case (code)
            CODE_ADD_SAT_W:  kind = K_ADD_SAT_W;
            CODE_ADD_WRAP_W: kind = K_ADD_WRAP_W;
            CODE_AND:        kind = K_AND;
            CODE_AND_NOT:    kind = K_AND_NOT;
            CODE_AVG_B:      kind = K_AVG_B;
            CODE_AVG_W:      kind = K_AVG_W;
            CODE_EQ_B:       kind = K_EQ_B;
            CODE_EQ_W:       kind = K_EQ_W;
            CODE_EQ_D:       kind = K_EQ_D;
            CODE_GT_B:       kind = K_GT_B;
            default: begin
                kind    = K_NONE;
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/simd_alu_lanes.sv
// Lane datapath: computes every lane-wise result in parallel and selects by kind.
// Assumes DATA_W is a multiple of 32; K_NONE yields zero.
module simd_alu_lanes
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  op_kind_e            kind,
    input  logic [DATA_W-1:0]   dst,
    input  logic [DATA_W-1:0]   src,
    output logic [DATA_W-1:0]   result
);

    localparam int B_W = 8;
    localparam int W_W = 16;
    localparam int D_W = 32;
    localparam int N_B = DATA_W / B_W;
    localparam int N_W = DATA_W / W_W;
    localparam int N_D = DATA_W / D_W;

    logic [DATA_W-1:0] avg_b, eq_b, gt_b;
    logic [DATA_W-1:0] sat_w, wrap_w, avg_w, eq_w;
    logic [DATA_W-1:0] eq_d;

    // Byte lanes: rounded average, equality mask, signed greater-than mask.
    for (genvar i = 0; i < N_B; i++) begin : g_byte
        logic [B_W-1:0] a, b;
        logic [B_W:0]   rsum;
        assign a    = dst[i*B_W +: B_W];
        assign b    = src[i*B_W +: B_W];
        assign rsum = {1'b0, a} + {1'b0, b} + {{B_W{1'b0}}, 1'b1};
        assign avg_b[i*B_W +: B_W] = rsum[B_W:1];
        assign eq_b[i*B_W +: B_W]  = {B_W{a == b}};
        assign gt_b[i*B_W +: B_W]  = {B_W{$signed(a) > $signed(b)}};
    end

    // Word lanes: saturating add, wrapping add, rounded average, equality mask.
    for (genvar i = 0; i < N_W; i++) begin : g_word
        logic [W_W-1:0] a, b;
        logic [W_W:0]   sum, rsum;
        assign a    = dst[i*W_W +: W_W];
        assign b    = src[i*W_W +: W_W];
        assign sum  = {1'b0, a} + {1'b0, b};
        assign rsum = sum + {{W_W{1'b0}}, 1'b1};
        assign sat_w[i*W_W +: W_W]  = sum[W_W] ? {W_W{1'b1}} : sum[W_W-1:0];
        assign wrap_w[i*W_W +: W_W] = sum[W_W-1:0];
        assign avg_w[i*W_W +: W_W]  = rsum[W_W:1];
        assign eq_w[i*W_W +: W_W]   = {W_W{a == b}};
    end

    // Dword lanes: equality mask.
    for (genvar i = 0; i < N_D; i++) begin : g_dword
        assign eq_d[i*D_W +: D_W] = {D_W{dst[i*D_W +: D_W] == src[i*D_W +: D_W]}};
    end

    // Select the lane result belonging to the requested operation.
    always_comb begin
        unique case (kind)
            K_ADD_SAT_W:  result = sat_w;
            K_ADD_WRAP_W: result = wrap_w;
            K_AND:        result = dst & src;
            K_AND_NOT:    result = ~dst & src;
            K_AVG_B:      result = avg_b;
            K_AVG_W:      result = avg_w;
            K_EQ_B:       result = eq_b;
            K_EQ_W:       result = eq_w;
            K_EQ_D:       result = eq_d;
            K_GT_B:       result = gt_b;
            default:      result = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu_stage.sv
// Pipeline stage: one valid bit and a data word, loaded when the stage may advance.
// Assumes: adv is high whenever the stage is empty or its content leaves this cycle.
module simd_alu_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         d_valid,
    input  logic [W-1:0] d_data,
    output logic         q_valid,
    output logic [W-1:0] q_data
);

    // Hold or replace the stage content; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else if (adv) begin
            q_valid <= d_valid;
            if (d_valid) begin
                q_data <= d_data;
            end
        end
    end

endmodule

// File: rtl/simd_alu_top.sv
// Top: two-stage packed SIMD ALU with valid/ready on both sides.
// Stage 1 registers the decoded kind and operands; stage 2 registers the result.
// Assumes one operation per cycle at most; results leave in order.
module simd_alu_top
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [7:0]        op_code,
    input  logic [DATA_W-1:0] op_dst,
    input  logic [DATA_W-1:0] op_src,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic              res_illegal
);

    localparam int S1_W = KIND_W + 1 + 2 * DATA_W;
    localparam int S2_W = 1 + DATA_W;

    op_kind_e          dec_kind;
    logic              dec_ill;
    logic              s1_valid, s2_valid;
    logic [S1_W-1:0]   s1_data;
    logic [S2_W-1:0]   s2_data;
    logic              adv1, adv2;
    op_kind_e          s1_kind;
    logic              s1_ill;
    logic [DATA_W-1:0] s1_dst, s1_src, lane_res;

    simd_alu_decode i_decode (
        .code    (op_code),
        .kind    (dec_kind),
        .illegal (dec_ill)
    );

    // Advance control: a stage moves when it is empty or the stage after it moves.
    always_comb begin
        adv2 = !s2_valid || res_ready;
        adv1 = !s1_valid || adv2;
    end

    assign op_ready = adv1;

    simd_alu_stage #(.W(S1_W)) i_stage1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv1),
        .d_valid (op_valid),
        .d_data  ({dec_kind, dec_ill, op_dst, op_src}),
        .q_valid (s1_valid),
        .q_data  (s1_data)
    );

    // Unpack the stage-1 word.
    always_comb begin
        s1_kind = op_kind_e'(s1_data[S1_W-1 -: KIND_W]);
        s1_ill  = s1_data[2*DATA_W];
        s1_dst  = s1_data[2*DATA_W-1 -: DATA_W];
        s1_src  = s1_data[DATA_W-1:0];
    end

    simd_alu_lanes #(.DATA_W(DATA_W)) i_lanes (
        .kind   (s1_kind),
        .dst    (s1_dst),
        .src    (s1_src),
        .result (lane_res)
    );

    simd_alu_stage #(.W(S2_W)) i_stage2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv2),
        .d_valid (s1_valid),
        .d_data  ({s1_ill, lane_res}),
        .q_valid (s2_valid),
        .q_data  (s2_data)
    );

    assign res_valid   = s2_valid;
    assign res_illegal = s2_data[DATA_W];
    assign res_data    = s2_data[DATA_W-1:0];

endmodule

// File: rtl/simd_alu_checker.sv
// Checker: handshake, latency and illegal-slot properties of simd_alu_top.
// Assumes it is bound to every instance of the top module.
module simd_alu_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic              res_valid,
    input logic              res_ready,
    input logic [DATA_W-1:0] res_data,
    input logic              res_illegal
);

    // R1: the first cycle out of reset shows an empty, accepting unit.
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!res_valid && op_ready));

    // R8: an illegal slot always carries a zero result.
    a_r8_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_illegal) |-> (res_data == '0));

    // R9: accepted work reaches the output two cycles later when not stalled.
    a_r9_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) ##1 res_ready |=> res_valid);

    // R10: a stalled result holds steady.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_illegal)));

    // R10: with nothing presented, the input side is never blocked.
    a_r10_accept_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> op_ready);

endmodule

bind simd_alu_top simd_alu_checker #(.DATA_W(DATA_W)) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid    (op_valid),
    .op_ready    (op_ready),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_data    (res_data),
    .res_illegal (res_illegal)
);

// File: tb/test_simd_alu_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model with an in-order queue, compared on every cycle.
module test_simd_alu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [7:0]  op_code = 8'h00;
    logic [63:0] op_dst = '0;
    logic [63:0] op_src = '0;
    logic        res_valid;
    logic        res_ready = 1'b1;
    logic [63:0] res_data;
    logic        res_illegal;

    int          total = 0;
    int          fails = 0;
    int          cyc = 0;
    bit          lat_chk = 1'b0;
    bit          rand_rdy = 1'b0;
    bit          last_acc = 1'b0;

    logic [63:0] q_res[$];
    bit          q_ill[$];
    int          q_cyc[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    simd_alu_top i_simd_alu_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_ready    (op_ready),
        .op_code     (op_code),
        .op_dst      (op_dst),
        .op_src      (op_src),
        .res_valid   (res_valid),
        .res_ready   (res_ready),
        .res_data    (res_data),
        .res_illegal (res_illegal)
    );

    function automatic string tag_of(input logic [7:0] c);
        case (c)
            8'hDD: return "R2";
            8'hFD: return "R3";
            8'hDB, 8'hDF: return "R4";
            8'hE0, 8'hE3: return "R5";
            8'h74, 8'h75, 8'h76: return "R6";
            8'h64: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Reference model written from the requirements.
    function automatic logic [63:0] ref_op(input logic [7:0] c, input logic [63:0] a,
                                           input logic [63:0] b, output bit ill);
        logic [63:0] r = '0;
        int unsigned s;
        byte sa, sb;
        ill = 1'b0;
        case (c)
            8'hDD: for (int k = 0; k < 4; k++) begin
                s = a[16*k +: 16] + b[16*k +: 16];
                r[16*k +: 16] = (s > 65535) ? 16'hFFFF : 16'(s);
            end
            8'hFD: for (int k = 0; k < 4; k++) begin
                s = a[16*k +: 16] + b[16*k +: 16];
                r[16*k +: 16] = 16'(s);
            end
            8'hDB: r = a & b;
            8'hDF: r = ~a & b;
            8'hE0: for (int k = 0; k < 8; k++) begin
                s = (a[8*k +: 8] + b[8*k +: 8] + 1) / 2;
                r[8*k +: 8] = 8'(s);
            end
            8'hE3: for (int k = 0; k < 4; k++) begin
                s = (a[16*k +: 16] + b[16*k +: 16] + 1) / 2;
                r[16*k +: 16] = 16'(s);
            end
            8'h74: for (int k = 0; k < 8; k++)
                r[8*k +: 8] = (a[8*k +: 8] == b[8*k +: 8]) ? 8'hFF : 8'h00;
            8'h75: for (int k = 0; k < 4; k++)
                r[16*k +: 16] = (a[16*k +: 16] == b[16*k +: 16]) ? 16'hFFFF : 16'h0000;
            8'h76: for (int k = 0; k < 2; k++)
                r[32*k +: 32] = (a[32*k +: 32] == b[32*k +: 32]) ? 32'hFFFF_FFFF : 32'h0;
            8'h64: for (int k = 0; k < 8; k++) begin
                sa = a[8*k +: 8];
                sb = b[8*k +: 8];
                r[8*k +: 8] = (sa > sb) ? 8'hFF : 8'h00;
            end
            default: begin
                ill = 1'b1;
                r = '0;
            end
        endcase
        return r;
    endfunction

    task automatic check(input string req, input bit ok, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // One cycle: settle, record transfers due at the next edge, move to the next negedge.
    task automatic tick();
        bit ill;
        logic [63:0] r;
        #1;
        last_acc = op_valid && op_ready;
        if (res_valid && res_ready) begin
            if (q_res.size() == 0) begin
                check("R10", 1'b0, res_data, 64'h0);
            end else begin
                check(q_tag[0], (res_data === q_res[0]) && (res_illegal === q_ill[0]),
                      {res_data[62:0], res_illegal}, {q_res[0][62:0], q_ill[0]});
                if (lat_chk) check("R9", (cyc - q_cyc[0]) == 2, 64'(cyc - q_cyc[0]), 64'd2);
                void'(q_res.pop_front());
                void'(q_ill.pop_front());
                void'(q_cyc.pop_front());
                void'(q_tag.pop_front());
            end
        end
        if (last_acc) begin
            r = ref_op(op_code, op_dst, op_src, ill);
            q_res.push_back(r);
            q_ill.push_back(ill);
            q_cyc.push_back(cyc);
            q_tag.push_back(tag_of(op_code));
        end
        @(negedge clk);
        cyc++;
        if (rand_rdy) res_ready = ($urandom % 4) != 0;
    endtask

    task automatic send(input logic [7:0] c, input logic [63:0] a, input logic [63:0] b);
        op_valid = 1'b1;
        op_code  = c;
        op_dst   = a;
        op_src   = b;
        do tick(); while (!last_acc);
        op_valid = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 50 && q_res.size() != 0; k++) tick();
        check("R10", q_res.size() == 0, 64'(q_res.size()), 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    logic [63:0] held;
    logic [7:0]  legal_codes [10] = '{8'hDD, 8'hFD, 8'hDB, 8'hDF, 8'hE0,
                                      8'hE3, 8'h74, 8'h75, 8'h76, 8'h64};

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle state after reset
        check("R1", !res_valid && op_ready, {62'd0, res_valid, op_ready}, 64'd1);
        @(negedge clk);
        cyc++;

        // Directed corner cases, consumer always ready.
        lat_chk = 1'b1;
        send(8'hDD, 64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_8000_0001); // R2 overflow edges
        send(8'hDD, 64'h7FFF_0000_1234_FFFE, 64'h8000_0000_0001_0001); // R2 just fits
        send(8'hFD, 64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_8000_0001); // R3 wrap
        send(8'hDB, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FF00_AAAA_FFFF); // R4 and
        send(8'hDF, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FF00_AAAA_FFFF); // R4 and-not
        send(8'hE0, 64'hFFFE_0100_FF01_8081, 64'hFFFF_0001_0001_7F80); // R5 byte avg
        send(8'hE3, 64'hFFFF_0000_8000_0001, 64'hFFFF_0001_8001_0002); // R5 word avg
        send(8'h74, 64'h1122_3344_5566_7788, 64'h1100_3300_5500_7700); // R6 bytes
        send(8'h75, 64'h1122_3344_5566_7788, 64'h1122_0000_5566_7789); // R6 words
        send(8'h76, 64'h1122_3344_5566_7788, 64'h1122_3344_5566_7789); // R6 dwords
        send(8'h64, 64'h7F80_0001_FF00_8080, 64'h807F_0100_00FF_8081); // R7 signed
        send(8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); // R8
        send(8'h65, 64'h1, 64'h2);                                     // R8 near code
        drain();
        lat_chk = 1'b0;

        // R10: fill both stages under stall, check blocking and holding.
        res_ready = 1'b0;
        send(8'hFD, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040);
        send(8'hDB, 64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0);
        op_valid = 1'b1;
        op_code  = 8'h74;
        op_dst   = 64'h0;
        op_src   = 64'h0;
        #1;
        check("R10", !op_ready && res_valid, {62'd0, op_ready, res_valid}, 64'd1);
        held = res_data;
        for (int k = 0; k < 3; k++) begin
            tick();
            #1;
            check("R10", res_data === held && !op_ready, res_data, held);
        end
        res_ready = 1'b1;
        do tick(); while (!last_acc);
        op_valid = 1'b0;
        drain();

        // Random mix with a randomly stalling consumer.
        rand_rdy = 1'b1;
        for (int n = 0; n < 400; n++) begin
            logic [7:0] c;
            logic [63:0] a, b;
            c = ($urandom % 8 == 0) ? 8'($urandom) : legal_codes[$urandom % 10];
            a = {$urandom, $urandom};
            b = ($urandom % 3 == 0) ? a ^ {32'd0, 24'd0, 8'($urandom % 2)} : {$urandom, $urandom};
            send(c, a, b);
            if ($urandom % 5 == 0) tick();
        end
        rand_rdy = 1'b0;
        res_ready = 1'b1;
        drain();
        report();
    end

endmodule